// File: doc/BRIEF.md
# SPI Byte Target

This block is the target end of a four-wire serial link. It trades one byte per frame with an external controller that drives the serial clock, the select line and the controller-to-target data line. The block answers on its own data output. All three incoming pins are brought into the system clock domain through synchronisers. Clock edges are found by comparing successive synchronised samples, so the system clock must run at least four times faster than the serial clock. The output driver enable follows the select line, so the data line is released whenever the target is not addressed.

Two configuration inputs set the clock idle level and the sampling phase. In phase 0 the select falling edge opens a byte, and the select line must rise before the next byte. In phase 1 the first clock edge opens a byte, so select may stay low across back-to-back bytes.

The byte to send enters through a valid/ready port. A one-byte holding register accepts a new byte whenever it is empty, and `tx_ready` is low while it is full. The received byte leaves through a valid/ready port. `rx_valid` stays high, with the data frozen, until `rx_ready` is seen high. A consumer that holds `rx_ready` high sees a one-cycle pulse per byte. If a byte completes while the previous one is still unaccepted, the new byte is dropped and `rx_overrun` pulses.

Top module: `spi_byte_target`

## Requirements
- R1: `miso_oe` is 1 while `ss_n` is 0 and 0 while `ss_n` is 1.
- R2: Each byte is 8 clock cycles long, shifted most significant bit first in both directions. `cfg_cpol` is the idle level of `sck`, and the leading edge of a cycle is the transition away from that level.
- R3: With `cfg_cpha`=0, bit 7 of the byte to send is on `miso` once `ss_n` is low, before the first `sck` edge. The target captures `mosi` on leading edges and advances `miso` on trailing edges.
- R4: With `cfg_cpha`=1, the first leading edge opens a byte, the target captures on trailing edges and advances on later leading edges, and several bytes may pass while `ss_n` stays low.
- R5: With `cfg_cpha`=0, after the eighth capture all further `sck` edges are ignored until `ss_n` goes high: no byte completes and no overrun is reported.
- R6: After the eighth capture `rx_valid` rises with the received byte on `rx_data`, and both hold unchanged until a cycle with `rx_ready`=1.
- R7: If a byte completes while `rx_valid`=1 and `rx_ready`=0, `rx_overrun` is 1 for one cycle, `rx_data` keeps the older byte, and the new byte is lost.
- R8: `ss_n` rising in the middle of a byte discards the partial byte and resets the bit count, so the next frame is received intact.
- R9: `tx_ready` is 1 while the holding register is empty. A byte accepted there moves into the shifter only between bytes with the target idle. With no byte loaded, the target sends 0x00.
- R10: After reset `rx_valid`=0, `rx_overrun`=0 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Sampling phase select |
| sck | input | 1 | Serial clock from controller |
| ss_n | input | 1 | Active-low target select |
| mosi | input | 1 | Serial data from controller |
| miso | output | 1 | Serial data to controller |
| miso_oe | output | 1 | Drive enable for `miso` |
| tx_valid | input | 1 | Byte to send is offered |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | Received byte is available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_overrun | output | 1 | One-cycle pulse when a received byte is dropped |

## Verification
The bench builds the block with its defaults: 8-bit bytes, two synchroniser stages and a fill byte of 0x00. The serial clock half-period is eight system cycles, so every edge clears the synchroniser and edge-detector latency, and the controller model samples `miso` exactly at each capture edge. With 8-bit bytes, all four clock modes, back-to-back phase-1 bytes, trailing edges after a completed phase-0 byte, a three-bit abort and an overrun each take only a few hundred cycles. The 0x00 fill value makes an empty holding register visible at the controller.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_XFER = 2'd1,
    ENG_HOLD = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
  import spi_tgt_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_FILL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              ss_s,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_take,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso_bit
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              armed;
  logic              sck_q;
  logic              rise, fall, lead, trail, cap, shf, last;

  assign rise  = ~sck_q & sck_s;
  assign fall  = sck_q & ~sck_s;
  assign lead  = cfg_cpol ? fall : rise;
  assign trail = cfg_cpol ? rise : fall;
  assign cap   = cfg_cpha ? trail : lead;
  assign shf   = cfg_cpha ? lead : trail;
  assign last  = (cnt == LAST_BIT);

  assign tx_take  = (st == ENG_IDLE) && !armed && tx_full;
  assign done     = (st == ENG_XFER) && !ss_s && cap && last;
  assign rx_byte  = {rx_sr[DATA_W-2:0], mosi_s};
  assign miso_bit = tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      cnt   <= '0;
      tx_sr <= IDLE_FILL;
      rx_sr <= '0;
      armed <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      // refill the shifter between bytes
      if (st == ENG_IDLE && !armed) begin
        tx_sr <= tx_full ? tx_data : IDLE_FILL;
        armed <= tx_full;
      end
      if (ss_s) begin
        st  <= ENG_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          ENG_IDLE: begin
            if (!cfg_cpha || lead) begin
              st    <= ENG_XFER;
              armed <= 1'b0;
            end
          end
          ENG_XFER: begin
            if (cap) begin
              rx_sr <= rx_byte;
              if (last) begin
                cnt <= '0;
                st  <= cfg_cpha ? ENG_IDLE : ENG_HOLD;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (shf) begin
              tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_tgt_rxq.sv
module spi_tgt_rxq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] byte_in,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_overrun
);
  logic blocked;
  assign blocked = rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_overrun <= 1'b0;
    end else begin
      rx_overrun <= done && blocked;
      if (done && !blocked) begin
        rx_data  <= byte_in;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_byte_target.sv
module spi_byte_target #(
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] IDLE_FILL   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_overrun
);
  logic [2:0]        pins_s;
  logic              sck_s, mosi_s, ss_s;
  logic              tx_full, tx_take, done;
  logic [DATA_W-1:0] tx_hold, rx_byte;

  spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, mosi, sck}), .q(pins_s)
  );
  assign sck_s  = pins_s[0];
  assign mosi_s = pins_s[1];
  assign ss_s   = pins_s[2];

  assign tx_ready = !tx_full;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (tx_valid && tx_ready) begin
      tx_full <= 1'b1;
      tx_hold <= tx_data;
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  spi_tgt_engine #(.DATA_W(DATA_W), .IDLE_FILL(IDLE_FILL)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sck_s(sck_s), .mosi_s(mosi_s), .ss_s(ss_s),
    .tx_full(tx_full), .tx_data(tx_hold), .tx_take(tx_take),
    .done(done), .rx_byte(rx_byte), .miso_bit(miso)
  );

  assign miso_oe = !ss_n;

  spi_tgt_rxq #(.DATA_W(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .done(done), .byte_in(rx_byte),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_overrun(rx_overrun)
  );
endmodule

// File: rtl/spi_byte_target_chk.sv
module spi_byte_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_overrun
);
  logic [2:0] ss_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ss_hi_cnt <= '0;
    else if (!ss_n)              ss_hi_cnt <= '0;
    else if (ss_hi_cnt != 3'd4)  ss_hi_cnt <= ss_hi_cnt + 1'b1;
  end

  // R6: unaccepted byte stays offered and frozen
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R7: an overrun only happens with a byte pending, which is kept
  p_overrun_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);

  p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $stable(rx_data));

  // R9: an accepted byte fills the holding register
  p_tx_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  // R8: with select long deasserted no byte can complete
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_hi_cnt == 3'd4) |-> !$rose(rx_valid));
endmodule

bind spi_byte_target spi_byte_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_overrun(rx_overrun)
);

// File: tb/spi_byte_target_tb.sv
module spi_byte_target_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid, rx_ready = 1'b0, rx_overrun;
  logic [7:0] rx_data;

  int errors = 0, checks = 0, ovr_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_byte_target u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_overrun(rx_overrun)
  );

  always @(posedge clk) if (rst_n && rx_overrun) ovr_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; sck = pol;
    wait_cyc(6);
  endtask

  task automatic load_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi = mo[i]; wait_cyc(HALF);
        mi[i] = miso; sck = ~cfg_cpol; wait_cyc(HALF);
        sck = cfg_cpol;
      end else begin
        sck = ~cfg_cpol; mosi = mo[i]; wait_cyc(HALF);
        mi[i] = miso; sck = cfg_cpol; wait_cyc(HALF);
      end
    end
  endtask

  task automatic session(input logic [7:0] mo, output logic [7:0] mi);
    ss_n = 1'b0; wait_cyc(HALF);
    spi_byte(mo, mi);
    wait_cyc(HALF);
    ss_n = 1'b1; wait_cyc(2 * HALF);
  endtask

  task automatic take_rx(input logic [7:0] exp, input string tag);
    check(rx_valid === 1'b1, {tag, " rx_valid"}, int'(rx_valid), 1);
    check(rx_data === exp, {tag, " rx_data"}, int'(rx_data), int'(exp));
    rx_ready = 1'b1; @(negedge clk);
    rx_ready = 1'b0; @(negedge clk);
    check(rx_valid === 1'b0, {tag, " rx_valid after accept"}, int'(rx_valid), 0);
  endtask

  task automatic t_reset();
    check(rx_valid === 1'b0, "R10 rx_valid", int'(rx_valid), 0);
    check(rx_overrun === 1'b0, "R10 rx_overrun", int'(rx_overrun), 0);
    check(tx_ready === 1'b1, "R10 tx_ready", int'(tx_ready), 1);
    check(miso_oe === 1'b0, "R1 oe released", int'(miso_oe), 0);
  endtask

  task automatic t_mode0();
    logic [7:0] got;
    set_mode(1'b0, 1'b0);
    load_tx(8'hA5);
    ss_n = 1'b0; wait_cyc(HALF);
    check(miso_oe === 1'b1, "R1 oe driven", int'(miso_oe), 1);
    check(miso === 1'b1, "R3 msb before first edge", int'(miso), 1);
    spi_byte(8'h3C, got);
    wait_cyc(HALF); ss_n = 1'b1; wait_cyc(2 * HALF);
    check(miso_oe === 1'b0, "R1 oe released after frame", int'(miso_oe), 0);
    check(got === 8'hA5, "R2 R3 mode0 miso byte", int'(got), 'hA5);
    wait_cyc(20);
    take_rx(8'h3C, "R6 mode0 held byte");
  endtask

  task automatic t_b2b();
    logic [7:0] g1, g2;
    set_mode(1'b1, 1'b1);
    load_tx(8'h81);
    ss_n = 1'b0; wait_cyc(HALF);
    spi_byte(8'hC3, g1);
    wait_cyc(HALF);
    check(g1 === 8'h81, "R4 b2b first miso", int'(g1), 'h81);
    take_rx(8'hC3, "R4 b2b first rx");
    load_tx(8'h7E);
    wait_cyc(HALF);
    spi_byte(8'h24, g2);
    wait_cyc(HALF);
    check(g2 === 8'h7E, "R4 b2b second miso", int'(g2), 'h7E);
    take_rx(8'h24, "R4 b2b second rx");
    ss_n = 1'b1; wait_cyc(2 * HALF);
  endtask

  task automatic t_other_modes();
    logic [7:0] g;
    set_mode(1'b1, 1'b0);
    load_tx(8'h96);
    session(8'h69, g);
    check(g === 8'h96, "R2 mode2 miso", int'(g), 'h96);
    take_rx(8'h69, "R2 mode2 rx");
    set_mode(1'b0, 1'b1);
    load_tx(8'h0F);
    session(8'hF0, g);
    check(g === 8'h0F, "R2 mode1 miso", int'(g), 'h0F);
    take_rx(8'hF0, "R2 mode1 rx");
  endtask

  task automatic t_cpha0_extra();
    logic [7:0] g, dummy;
    int ovr0;
    set_mode(1'b0, 1'b0);
    load_tx(8'h11);
    ss_n = 1'b0; wait_cyc(HALF);
    spi_byte(8'hE7, g);
    wait_cyc(HALF);
    load_tx(8'h22);
    wait_cyc(10);
    check(tx_ready === 1'b0, "R9 hold kept while mid frame", int'(tx_ready), 0);
    ovr0 = ovr_cnt;
    spi_byte(8'hFF, dummy);
    wait_cyc(HALF);
    check(ovr_cnt == ovr0, "R5 no overrun from extra edges", ovr_cnt, ovr0);
    check(rx_data === 8'hE7, "R5 extra edges ignored", int'(rx_data), 'hE7);
    ss_n = 1'b1; wait_cyc(2 * HALF);
    check(g === 8'h11, "R3 mode0 miso", int'(g), 'h11);
    check(tx_ready === 1'b1, "R9 hold consumed when idle", int'(tx_ready), 1);
    take_rx(8'hE7, "R5 rx");
  endtask

  task automatic t_overrun();
    logic [7:0] g;
    int ovr0;
    ovr0 = ovr_cnt;
    session(8'hA1, g);
    check(g === 8'h22, "R9 queued byte sent", int'(g), 'h22);
    session(8'hB2, g);
    check(ovr_cnt == ovr0 + 1, "R7 overrun pulse", ovr_cnt, ovr0 + 1);
    check(rx_overrun === 1'b0, "R7 overrun is a pulse", int'(rx_overrun), 0);
    take_rx(8'hA1, "R7 older byte kept");
  endtask

  task automatic t_abort();
    logic [7:0] g;
    ss_n = 1'b0; wait_cyc(HALF);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; wait_cyc(HALF);
      sck = 1'b1; wait_cyc(HALF);
      sck = 1'b0;
    end
    wait_cyc(HALF);
    ss_n = 1'b1; wait_cyc(2 * HALF);
    check(rx_valid === 1'b0, "R8 partial byte discarded", int'(rx_valid), 0);
    session(8'h5A, g);
    take_rx(8'h5A, "R8 next frame intact");
    check(g === 8'h00, "R9 fill byte when empty", int'(g), 0);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_mode0();
    t_b2b();
    t_other_modes();
    t_cpha0_extra();
    t_overrun();
    t_abort();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule